// File: doc/BRIEF.md
# Two-Channel Byte DMA Controller

This block moves single bytes between any two addresses of a 64 KB space on behalf of two independent channels. Each channel has a 16-bit source pointer, a 16-bit destination pointer and a 16-bit transfer counter. A channel is started either by software, through a trigger bit in its mode register, or by a rising edge on one of sixteen shared request lines, chosen by a 4-bit select field. Every byte costs one bus read cycle, which loads an internal holding register, and then one bus write cycle. The CPU is held in a stall during both cycles.

The CPU programs the block through a byte-wide register port. One bank-select bit in the status register maps either channel's mode, pointer and counter registers onto a single shared set of addresses. A write to a pointer or counter byte also loads a reload copy, and a reload command later restores the working registers from those copies. In single mode a channel moves one byte per trigger. In burst mode one trigger moves bytes back to back until the counter underflows from zero. An underflow sets the channel's flag and interrupt and clears its enable bit. Channel 0 wins when both channels are ready. A cycle with the CPU running always separates transfers that belong to different triggers or to different channels. An inhibit input, meant for wait, stop and hold states, stops new transfers from starting.

Top module: `dma2_top`

## Requirements
- R1: After reset, every output is 0, every register reads 0, and the status bank bit is 0.
- R2: Register address 0 is status. Its bit 7 is the bank select (0 = channel 0, 1 = channel 1) and its bits 1:0 are the underflow flags of channels 1:0. Addresses 1 to 8 (mode1, mode2, source low/high, destination low/high, count low/high) read and write only the channel the bank bit selects.
- R3: Each byte takes a read cycle (mem_rd_o=1, mem_addr_o=source), then at once a write cycle (mem_wr_o=1, mem_addr_o=destination, mem_wdata_o=byte read). cpu_stall_o is 1 in exactly those cycles.
- R4: At least one cycle with cpu_stall_o=0 separates two bytes unless both belong to the same burst of the same channel; burst bytes follow each other with no gap.
- R5: In single mode (mode1 bit 1 = 0), one byte moves per trigger. A trigger is a write of mode1 with bit 2 set, or a 0-to-1 edge on req_i[mode2 bits 3:0]. A request line held high counts once.
- R6: In burst mode (mode1 bit 1 = 1), one trigger moves bytes until the counter underflows, so a count of N moves N+1 bytes.
- R7: The counter drops by 1 per byte. A byte moved with the count at 0 wraps it to 0xFFFF, sets the channel's status flag and irq_o bit, and clears mode1 bit 0 (enable). Writing 1 to a flag bit of status clears it.
- R8: After each byte, the source address changes by +1, or by -1 when mode1 bit 3 is set, and stays fixed when mode1 bit 4 is set. The destination follows the same rule using bits 5 and 6.
- R9: When both channels are ready in the same idle cycle, channel 0 is served first and channel 1 follows after a gap cycle.
- R10: While inhibit_i=1, no transfer starts and a burst does not continue. A pending trigger is served after inhibit_i falls.
- R11: Writing mode2 with bit 4 set restores source, destination and count from the values last written to their registers. Bit 4 reads as 0.
- R12: A channel with mode1 bit 0 = 0 ignores request edges: it moves no byte and its count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| req_i | input | NUM_REQ | Shared request lines, edge triggered |
| inhibit_i | input | 1 | Blocks new transfers (wait/stop/hold) |
| mem_addr_o | output | 16 | Bus address |
| mem_rd_o | output | 1 | Bus read strobe |
| mem_wr_o | output | 1 | Bus write strobe |
| mem_wdata_o | output | 8 | Bus write data |
| mem_rdata_i | input | 8 | Bus read data, valid in the read cycle |
| cpu_stall_o | output | 1 | Holds the CPU during transfer cycles |
| irq_o | output | 2 | Per-channel underflow interrupt |

## Verification
The properties assume that the CPU writes registers only in cycles where cpu_stall_o is low. The bench keeps to this: it issues every register write only after waiting long enough for any running transfer or burst to finish. The properties also assume that mem_rdata_i is valid during the read cycle. The bench drives it as a fixed function of mem_addr_o, so the expected write data follows from the source address alone.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int RAW = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RD, SQ_WR} seq_e;

  localparam logic [RAW-1:0] RA_STAT  = 4'd0;
  localparam logic [RAW-1:0] RA_MODE1 = 4'd1;
  localparam logic [RAW-1:0] RA_MODE2 = 4'd2;
  localparam logic [RAW-1:0] RA_SRCL  = 4'd3;
  localparam logic [RAW-1:0] RA_SRCH  = 4'd4;
  localparam logic [RAW-1:0] RA_DSTL  = 4'd5;
  localparam logic [RAW-1:0] RA_DSTH  = 4'd6;
  localparam logic [RAW-1:0] RA_CNTL  = 4'd7;
  localparam logic [RAW-1:0] RA_CNTH  = 4'd8;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [RAW-1:0]     wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [NUM_REQ-1:0] req_rise_i,
  input  logic               step_i,
  input  logic [RAW-1:0]     rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [AW-1:0]      src_o,
  output logic [AW-1:0]      dst_o,
  output logic               cnt_zero_o,
  output logic               ready_o,
  output logic               burst_o,
  output logic               uflow_o
);
  localparam int SEL_W = $clog2(NUM_REQ);

  logic en_q, burst_q, sdec_q, shold_q, ddec_q, dhold_q, pend_q;
  logic [SEL_W-1:0] sel_q;
  logic [AW-1:0] src_q, dst_q, cnt_q, src_l, dst_l, cnt_l;
  logic w_m1, en_n, ev, keep;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic dec, input logic hold);
    if (hold) return a;
    return dec ? a - AW'(1) : a + AW'(1);
  endfunction

  assign w_m1    = wr_en_i && (wr_addr_i == RA_MODE1);
  assign uflow_o = step_i && (cnt_q == '0);
  assign ev      = req_rise_i[sel_q] || (w_m1 && wr_data_i[2]);
  // single: a byte consumes the trigger; burst: only underflow does
  assign keep    = pend_q && !(step_i && (!burst_q || uflow_o));

  always_comb begin
    en_n = en_q;
    if (uflow_o) en_n = 1'b0;
    if (w_m1)    en_n = wr_data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; burst_q <= 1'b0; sdec_q <= 1'b0; shold_q <= 1'b0;
      ddec_q <= 1'b0; dhold_q <= 1'b0; pend_q <= 1'b0; sel_q <= '0;
      src_q <= '0; dst_q <= '0; cnt_q <= '0;
      src_l <= '0; dst_l <= '0; cnt_l <= '0;
    end else begin
      en_q   <= en_n;
      pend_q <= en_n && (ev || keep);
      if (step_i) begin
        src_q <= adv(src_q, sdec_q, shold_q);
        dst_q <= adv(dst_q, ddec_q, dhold_q);
        cnt_q <= cnt_q - AW'(1);
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          RA_MODE1: begin
            burst_q <= wr_data_i[1];
            sdec_q  <= wr_data_i[3];
            shold_q <= wr_data_i[4];
            ddec_q  <= wr_data_i[5];
            dhold_q <= wr_data_i[6];
          end
          RA_MODE2: begin
            sel_q <= wr_data_i[SEL_W-1:0];
            if (wr_data_i[4]) begin
              src_q <= src_l; dst_q <= dst_l; cnt_q <= cnt_l;
            end
          end
          RA_SRCL: begin src_q[7:0]  <= wr_data_i; src_l[7:0]  <= wr_data_i; end
          RA_SRCH: begin src_q[15:8] <= wr_data_i; src_l[15:8] <= wr_data_i; end
          RA_DSTL: begin dst_q[7:0]  <= wr_data_i; dst_l[7:0]  <= wr_data_i; end
          RA_DSTH: begin dst_q[15:8] <= wr_data_i; dst_l[15:8] <= wr_data_i; end
          RA_CNTL: begin cnt_q[7:0]  <= wr_data_i; cnt_l[7:0]  <= wr_data_i; end
          RA_CNTH: begin cnt_q[15:8] <= wr_data_i; cnt_l[15:8] <= wr_data_i; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      RA_MODE1: rd_data_o = {1'b0, dhold_q, ddec_q, shold_q, sdec_q, 1'b0, burst_q, en_q};
      RA_MODE2: rd_data_o[SEL_W-1:0] = sel_q;
      RA_SRCL:  rd_data_o = src_q[7:0];
      RA_SRCH:  rd_data_o = src_q[15:8];
      RA_DSTL:  rd_data_o = dst_q[7:0];
      RA_DSTH:  rd_data_o = dst_q[15:8];
      RA_CNTL:  rd_data_o = cnt_q[7:0];
      RA_CNTH:  rd_data_o = cnt_q[15:8];
      default:  rd_data_o = '0;
    endcase
  end

  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign ready_o    = en_q && pend_q;
  assign burst_o    = burst_q;
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
  import dma2_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    ready_i,
  input  logic [1:0]    burst_i,
  input  logic [1:0]    last_i,
  input  logic          inhibit_i,
  input  logic [DW-1:0] rdata_i,
  output seq_e          state_o,
  output logic          gnt_o,
  output logic [DW-1:0] tmp_o,
  output logic [1:0]    step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= SQ_IDLE;
      gnt_o   <= 1'b0;
      tmp_o   <= '0;
    end else begin
      case (state_o)
        SQ_IDLE: if (!inhibit_i && (|ready_i)) begin
          state_o <= SQ_RD;
          gnt_o   <= !ready_i[0]; // channel 0 first
        end
        SQ_RD: begin
          tmp_o   <= rdata_i;
          state_o <= SQ_WR;
        end
        SQ_WR: state_o <= (burst_i[gnt_o] && !last_i[gnt_o] && !inhibit_i) ? SQ_RD : SQ_IDLE;
        default: state_o <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    step_o = '0;
    if (state_o == SQ_WR) step_o[gnt_o] = 1'b1;
  end
endmodule

// File: rtl/dma2_top.sv
module dma2_top
  import dma2_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [3:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               inhibit_i,
  output logic [15:0]        mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i,
  output logic               cpu_stall_o,
  output logic [1:0]         irq_o
);
  localparam int NCH = 2;

  logic [NUM_REQ-1:0] req_q, rise_w;
  logic bank_q;
  logic [NCH-1:0] flag_q, rdy_w, burst_w, last_w, uflow_w, step_w;
  logic [NCH-1:0][AW-1:0] src_w, dst_w;
  logic [NCH-1:0][DW-1:0] chrd_w;
  logic gnt_w;
  logic [DW-1:0] tmp_w;
  seq_e state_w;
  logic wr_stat;

  assign rise_w  = req_i & ~req_q;
  assign wr_stat = reg_we_i && (reg_addr_i == RA_STAT);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2_chan #(.NUM_REQ(NUM_REQ)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (reg_we_i && (reg_addr_i != RA_STAT) && (bank_q == (c == 1))),
      .wr_addr_i  (reg_addr_i),
      .wr_data_i  (reg_wdata_i),
      .req_rise_i (rise_w),
      .step_i     (step_w[c]),
      .rd_addr_i  (reg_addr_i),
      .rd_data_o  (chrd_w[c]),
      .src_o      (src_w[c]),
      .dst_o      (dst_w[c]),
      .cnt_zero_o (last_w[c]),
      .ready_o    (rdy_w[c]),
      .burst_o    (burst_w[c]),
      .uflow_o    (uflow_w[c])
    );
  end

  dma2_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (rdy_w),
    .burst_i   (burst_w),
    .last_i    (last_w),
    .inhibit_i (inhibit_i),
    .rdata_i   (mem_rdata_i),
    .state_o   (state_w),
    .gnt_o     (gnt_w),
    .tmp_o     (tmp_w),
    .step_o    (step_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      bank_q <= 1'b0;
      flag_q <= '0;
    end else begin
      req_q <= req_i;
      if (wr_stat) bank_q <= reg_wdata_i[7];
      flag_q <= (flag_q & ~(wr_stat ? reg_wdata_i[NCH-1:0] : '0)) | uflow_w;
    end
  end

  assign mem_rd_o    = (state_w == SQ_RD);
  assign mem_wr_o    = (state_w == SQ_WR);
  assign mem_addr_o  = mem_rd_o ? src_w[gnt_w] : (mem_wr_o ? dst_w[gnt_w] : '0);
  assign mem_wdata_o = mem_wr_o ? tmp_w : '0;
  assign cpu_stall_o = mem_rd_o || mem_wr_o;
  assign irq_o       = flag_q;
  assign reg_rdata_o = (reg_addr_i == RA_STAT) ? {bank_q, 5'b0, flag_q} : chrd_w[bank_q];
endmodule

// File: rtl/dma2_chk.sv
module dma2_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       cpu_stall_o,
  input logic       inhibit_i,
  input logic [1:0] irq_o,
  input logic       gnt_w,
  input logic [1:0] rdy_w,
  input logic [1:0] burst_w
);
  assert_rd_then_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_wr_o);
  assert_wr_after_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_o) |-> $past(mem_rd_o));
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));
  assert_no_gap_only_burst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_wr_o)) |-> (gnt_w == $past(gnt_w)) && burst_w[gnt_w]);
  assert_inhibit_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && !cpu_stall_o) |=> !mem_rd_o);
  assert_prio_ch0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_stall_o && !inhibit_i && rdy_w[0]) |=> (mem_rd_o && !gnt_w));
  assert_serve_ch1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_stall_o && !inhibit_i && !rdy_w[0] && rdy_w[1]) |=> (mem_rd_o && gnt_w));
  assert_irq0_on_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> $past(mem_wr_o));
  assert_irq1_on_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[1]) |-> $past(mem_wr_o));
endmodule

bind dma2_top dma2_chk u_chk (.*);

// File: tb/sim_dma2_top.sv
`timescale 1ns/1ps
module sim_dma2_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] raddr = '0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic [15:0] req = '0;
  logic inh = 1'b0;
  logic [15:0] maddr;
  logic mrd, mwr, stall;
  logic [7:0] mwdata, mrdata;
  logic [1:0] irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mrdata = memf(maddr);

  dma2_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdat), .reg_rdata_o(rdat), .req_i(req), .inhibit_i(inh),
    .mem_addr_o(maddr), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .cpu_stall_o(stall), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_src[2], m_dst[2], m_cnt[2], l_src[2], l_dst[2], l_cnt[2];
  logic [3:0]  m_sel[2];
  logic m_en[2], m_bu[2], m_sd[2], m_sh[2], m_dd[2], m_dh[2], m_pd[2];
  logic [1:0] m_flag;
  logic m_bank, m_ch;
  logic [7:0] m_tmp;
  logic [15:0] m_reqq;
  int m_state;

  function automatic logic [15:0] nxt(input logic [15:0] a, input logic d, input logic h);
    if (h) return a;
    return d ? a - 16'd1 : a + 16'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; l_src[c] = 0; l_dst[c] = 0; l_cnt[c] = 0;
        m_sel[c] = 0; m_en[c] = 0; m_bu[c] = 0; m_sd[c] = 0; m_sh[c] = 0;
        m_dd[c] = 0; m_dh[c] = 0; m_pd[c] = 0;
      end
      m_flag = 0; m_bank = 0; m_ch = 0; m_tmp = 0; m_reqq = 0; m_state = 0;
    end else begin
      int ns;
      logic nch;
      logic [15:0] rise;
      logic [1:0] uf;
      rise = req & ~m_reqq;
      ns = m_state; nch = m_ch; uf = 0;
      case (m_state)
        0: if (!inh && ((m_en[0] && m_pd[0]) || (m_en[1] && m_pd[1]))) begin
             ns = 1; nch = (m_en[0] && m_pd[0]) ? 1'b0 : 1'b1;
           end
        1: begin m_tmp = memf(m_src[m_ch]); ns = 2; end
        default: ns = (m_bu[m_ch] && m_cnt[m_ch] != 0 && !inh) ? 1 : 0;
      endcase
      for (int c = 0; c < 2; c++) begin
        logic stp, wsel, ev, en_n, kp;
        stp  = (m_state == 2) && (m_ch == c[0]);
        wsel = we && raddr != 0 && m_bank == c[0];
        uf[c] = stp && m_cnt[c] == 0;
        ev   = rise[m_sel[c]] || (wsel && raddr == 1 && wdat[2]);
        en_n = m_en[c];
        if (uf[c]) en_n = 0;
        if (wsel && raddr == 1) en_n = wdat[0];
        kp = m_pd[c] && !(stp && (!m_bu[c] || uf[c]));
        if (stp) begin
          m_src[c] = nxt(m_src[c], m_sd[c], m_sh[c]);
          m_dst[c] = nxt(m_dst[c], m_dd[c], m_dh[c]);
          m_cnt[c] = m_cnt[c] - 16'd1;
        end
        if (wsel) case (raddr)
          1: begin m_bu[c] = wdat[1]; m_sd[c] = wdat[3]; m_sh[c] = wdat[4]; m_dd[c] = wdat[5]; m_dh[c] = wdat[6]; end
          2: begin m_sel[c] = wdat[3:0];
                   if (wdat[4]) begin m_src[c] = l_src[c]; m_dst[c] = l_dst[c]; m_cnt[c] = l_cnt[c]; end end
          3: begin m_src[c][7:0] = wdat;  l_src[c][7:0] = wdat;  end
          4: begin m_src[c][15:8] = wdat; l_src[c][15:8] = wdat; end
          5: begin m_dst[c][7:0] = wdat;  l_dst[c][7:0] = wdat;  end
          6: begin m_dst[c][15:8] = wdat; l_dst[c][15:8] = wdat; end
          7: begin m_cnt[c][7:0] = wdat;  l_cnt[c][7:0] = wdat;  end
          8: begin m_cnt[c][15:8] = wdat; l_cnt[c][15:8] = wdat; end
          default: ;
        endcase
        m_pd[c] = en_n && (ev || kp);
        m_en[c] = en_n;
      end
      m_flag = (m_flag & ~((we && raddr == 0) ? wdat[1:0] : 2'b00)) | uf;
      if (we && raddr == 0) m_bank = wdat[7];
      m_reqq = req;
      m_state = ns; m_ch = nch;
    end
  end

  function automatic logic [7:0] m_rd(input logic [3:0] a);
    int b;
    b = m_bank;
    case (a)
      0: return {m_bank, 5'b0, m_flag};
      1: return {1'b0, m_dh[b], m_dd[b], m_sh[b], m_sd[b], 1'b0, m_bu[b], m_en[b]};
      2: return {4'b0, m_sel[b]};
      3: return m_src[b][7:0];
      4: return m_src[b][15:8];
      5: return m_dst[b][7:0];
      6: return m_dst[b][15:8];
      7: return m_cnt[b][7:0];
      8: return m_cnt[b][15:8];
      default: return 8'h00;
    endcase
  endfunction

  // ---------------- monitors and per-cycle compare ----------------
  int wr_cnt = 0, run = 0, max_run = 0, nrd = 0;
  logic [15:0] rd_log[4];
  logic [7:0] last_wd;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] e_addr;
      e_addr = (m_state == 1) ? m_src[m_ch] : (m_state == 2) ? m_dst[m_ch] : 16'h0;
      chk("R3 rd strobe", mrd, m_state == 1);
      chk("R3 wr strobe", mwr, m_state == 2);
      chk("R3 bus addr", maddr, e_addr);
      chk("R3 wdata", mwdata, (m_state == 2) ? m_tmp : 8'h00);
      chk("R4 stall", stall, m_state != 0);
      chk("R7 irq", irq, m_flag);
      chk("R2 rdata", rdat, m_rd(raddr));
      if (mwr) begin wr_cnt++; last_wd = mwdata; end
      if (mrd) begin if (nrd < 4) rd_log[nrd] = maddr; nrd++; end
      if (stall) begin run++; if (run > max_run) max_run = run; end else run = 0;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1; we = 1; raddr = a; wdat = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] v);
    @(posedge clk); #1; raddr = a;
    @(negedge clk); #0.5; v = rdat;
  endtask

  task automatic pulse(input int idx, input int hold);
    @(posedge clk); #1; req[idx] = 1'b1;
    repeat (hold) @(posedge clk);
    #1; req[idx] = 1'b0;
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
    wreg(3, s[7:0]); wreg(4, s[15:8]); wreg(5, d[7:0]); wreg(6, d[15:8]);
    wreg(7, n[7:0]); wreg(8, n[15:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int w0;
    idle(3);
    // R1: reset state
    @(negedge clk);
    chk("R1 outputs", {maddr, mrd, mwr, mwdata, stall, irq}, 0);
    for (int a = 0; a < 9; a++) begin rreg(a[3:0], v); chk("R1 reg zero", v, 0); end
    #1 rst_n = 1'b1;
    idle(2);

    // R2: banking
    wreg(0, 8'h80); wreg(3, 8'h34);
    rreg(3, v); chk("R2 bank1 src", v, 8'h34);
    rreg(0, v); chk("R2 status bank bit", v, 8'h80);
    wreg(0, 8'h00);
    rreg(3, v); chk("R2 bank0 src", v, 8'h00);

    // R5/R3/R8: single sw trigger
    setup(16'h1000, 16'h2000, 16'd2);
    w0 = wr_cnt; wreg(1, 8'h05); idle(8);
    chk("R5 sw one byte", wr_cnt - w0, 1);
    chk("R3 moved data", last_wd, memf(16'h1000));
    rreg(3, v); chk("R8 src inc", v, 8'h01);
    rreg(5, v); chk("R8 dst inc", v, 8'h01);
    rreg(7, v); chk("R7 count dec", v, 8'h01);
    rreg(1, v); chk("R5 sw bit reads 0", v, 8'h01);

    // R5: hw edge, held high counts once
    wreg(2, 8'h03);
    w0 = wr_cnt; pulse(3, 6); idle(8);
    chk("R5 hw held once", wr_cnt - w0, 1);
    rreg(7, v); chk("R7 count 0", v, 8'h00);
    // R7: underflow
    w0 = wr_cnt; pulse(3, 1); idle(8);
    chk("R7 last byte", wr_cnt - w0, 1);
    rreg(7, v); chk("R7 wrap lo", v, 8'hFF);
    rreg(8, v); chk("R7 wrap hi", v, 8'hFF);
    chk("R7 irq set", irq, 2'b01);
    rreg(0, v); chk("R7 flag", v, 8'h01);
    rreg(1, v); chk("R7 enable cleared", v, 8'h00);
    wreg(0, 8'h01); idle(1);
    chk("R7 irq cleared", irq, 2'b00);

    // R6/R8/R4: burst, src decrement, dst hold
    setup(16'h3000, 16'h4000, 16'd1);
    w0 = wr_cnt; max_run = 0; wreg(1, 8'h4F); idle(12);
    chk("R6 burst N+1", wr_cnt - w0, 2);
    chk("R4 burst back to back", max_run, 4);
    rreg(3, v); chk("R8 src dec lo", v, 8'hFE);
    rreg(4, v); chk("R8 src dec hi", v, 8'h2F);
    rreg(5, v); chk("R8 dst hold lo", v, 8'h00);
    rreg(6, v); chk("R8 dst hold hi", v, 8'h40);
    wreg(0, 8'h01);

    // R9: priority
    wreg(0, 8'h80); setup(16'h6000, 16'h7000, 16'd0); wreg(2, 8'h05); wreg(1, 8'h01);
    wreg(0, 8'h00); setup(16'h6100, 16'h7100, 16'd0); wreg(2, 8'h05); wreg(1, 8'h01);
    w0 = wr_cnt; nrd = 0; max_run = 0; pulse(5, 1); idle(12);
    chk("R9 both served", wr_cnt - w0, 2);
    chk("R9 ch0 first", rd_log[0], 16'h6100);
    chk("R9 ch1 second", rd_log[1], 16'h6000);
    chk("R4 gap between channels", max_run, 2);
    chk("R7 both irq", irq, 2'b11);
    wreg(0, 8'h03); idle(1);
    chk("R7 both cleared", irq, 2'b00);

    // R10: inhibit
    setup(16'h8000, 16'h9000, 16'd5);
    @(posedge clk); #1 inh = 1'b1;
    w0 = wr_cnt; wreg(1, 8'h05); idle(10);
    chk("R10 blocked", wr_cnt - w0, 0);
    @(posedge clk); #1 inh = 1'b0; idle(8);
    chk("R10 served after", wr_cnt - w0, 1);

    // R11: reload
    rreg(3, v); chk("R11 pre src", v, 8'h01);
    wreg(2, 8'h15);
    rreg(3, v); chk("R11 src restored", v, 8'h00);
    rreg(5, v); chk("R11 dst restored", v, 8'h00);
    rreg(7, v); chk("R11 count restored", v, 8'h05);
    rreg(2, v); chk("R11 reload reads 0", v, 8'h05);

    // R12: disabled channel ignores requests
    wreg(1, 8'h00);
    w0 = wr_cnt; pulse(5, 1); idle(8);
    chk("R12 no byte", wr_cnt - w0, 0);
    rreg(7, v); chk("R12 count kept", v, 8'h05);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule